// File: doc/BRIEF.md
# Write-Streaming Allocation Mode Detector

This block sits beside a write-back L1 data cache and decides when write misses should stop pulling lines into the cache. When software streams whole cache lines out to memory, filling the line first only to overwrite it wastes bandwidth and evicts useful data. The detector watches three event streams: completed linefills, cacheable write bursts, and loads. Each linefill completion carries a flag that says whether the whole line had been written before the fill finished. Each write burst carries a full-line flag and a line address. Each load carries a line address.

There are two independent mode flags. The L1 flag is raised after a run of linefills whose lines were fully overwritten. While it is set, write misses go to the next level instead of starting a fill. Loads still allocate. The L2 flag is raised after a much longer run of full-line write bursts. It has effect only when an L2 cache is present. Both flags are dropped by a partial-line cacheable burst, or by a load to the line that is currently being streamed out. Dropping a flag also clears its run count, so a fresh run is needed to enter the mode again.

Top module: `wsd_top`

## Requirements
- R1: After a synchronous reset, `l1_stream_mode` and `l2_stream_mode` are both 0.
- R2: `l1_stream_mode` rises one clock after the L1_THRESH-th consecutive linefill completion that has `lf_full`=1 (default 3). It is not set after L1_THRESH-1 such completions.
- R3: A linefill completion with `lf_full`=0 sets the L1 run count back to zero. It does not change a mode that is already set.
- R4: A write burst with `wb_full`=0 clears both mode flags and both run counts on the next clock.
- R5: The streamed line is the line address of the most recent full-line burst. A partial burst invalidates it. A load whose `ld_line` equals the valid streamed line clears both flags and both run counts on the next clock. A load to any other line has no effect.
- R6: When `l2_present`=1, `l2_stream_mode` rises one clock after the L2_THRESH-th consecutive full-line burst (default 127). It is not set after L2_THRESH-1 such bursts.
- R7: While `l2_present`=0, `l2_stream_mode` stays 0 and the L2 run count stays at zero.
- R8: Run counts saturate at their thresholds. A flag stays set through any number of further qualifying events.
- R9: When an exit condition and a qualifying event fall in the same clock, the exit condition wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l2_present | input | 1 | L2 cache is present |
| lf_valid | input | 1 | A linefill has completed this cycle |
| lf_full | input | 1 | That line was fully written before the fill completed |
| wb_valid | input | 1 | A cacheable write burst is seen this cycle |
| wb_full | input | 1 | The burst covers a whole cache line |
| wb_line | input | LINE_W | Line address of the burst |
| ld_valid | input | 1 | A load request is seen this cycle |
| ld_line | input | LINE_W | Line address of the load |
| l1_stream_mode | output | 1 | L1 write misses bypass allocation |
| l2_stream_mode | output | 1 | L2 write misses bypass allocation |

## Verification
Runs of fully overwritten linefills are stopped one short of the threshold and also taken to it. This tells an off-by-one entry apart from a correct one. A partial fill placed inside a run shows whether the run count really resets. Loads are sent both to the streamed line and to other lines, and also before any burst has set a streamed line. This separates a real address match from a mode that drops on any load. A 127-burst run is made with the L2 present and again with it absent, and is broken by a partial burst. These cases show the L2 gating, the long threshold and the secondary reset. Exit and qualifying events are also placed in the same cycle to check which takes priority.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

    typedef enum logic {
        ALLOC_NORMAL = 1'b0,
        ALLOC_STREAM = 1'b1
    } alloc_mode_e;

    typedef struct packed {
        logic enable;
        logic step;
        logic restart;
        logic leave;
    } mode_ctrl_t;

    function automatic logic line_hit(input logic valid, input logic match);
        return valid && match;
    endfunction

endpackage

// File: rtl/wsd_stream_line.sv
module wsd_stream_line #(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_valid,
    input  logic              wb_full,
    input  logic [LINE_W-1:0] wb_line,
    input  logic              ld_valid,
    input  logic [LINE_W-1:0] ld_line,
    output logic              load_hit
);
    logic              held_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            line_q <= '0;
        end else if (wb_valid) begin
            held_q <= wb_full;
            if (wb_full) line_q <= wb_line;
        end
    end

    assign load_hit = wsd_pkg::line_hit(ld_valid && held_q, ld_line == line_q);
endmodule

// File: rtl/wsd_mode_ctl.sv
module wsd_mode_ctl
    import wsd_pkg::*;
#(
    parameter int THRESH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  mode_ctrl_t ctrl,
    output logic       mode
);
    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    logic [CW-1:0] run_q, run_d;
    alloc_mode_e   st_q, st_d;

    always_comb begin
        run_d = run_q;
        st_d  = st_q;
        if (!ctrl.enable || ctrl.leave) begin
            run_d = '0;
            st_d  = ALLOC_NORMAL;
        end else if (ctrl.restart) begin
            run_d = '0;
        end else if (ctrl.step) begin
            if (run_q < LIMIT) run_d = run_q + 1'b1;
            if (run_d >= LIMIT) st_d = ALLOC_STREAM;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            st_q  <= ALLOC_NORMAL;
        end else begin
            run_q <= run_d;
            st_q  <= st_d;
        end
    end

    assign mode = (st_q == ALLOC_STREAM);
endmodule

// File: rtl/wsd_top.sv
module wsd_top
    import wsd_pkg::*;
#(
    parameter int LINE_W    = 26,
    parameter int L1_THRESH = 3,
    parameter int L2_THRESH = 127
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l2_present,
    input  logic              lf_valid,
    input  logic              lf_full,
    input  logic              wb_valid,
    input  logic              wb_full,
    input  logic [LINE_W-1:0] wb_line,
    input  logic              ld_valid,
    input  logic [LINE_W-1:0] ld_line,
    output logic              l1_stream_mode,
    output logic              l2_stream_mode
);
    localparam int LEVELS = 2;

    logic       load_hit;
    logic       leave;
    mode_ctrl_t ctrl [LEVELS];
    logic       mode [LEVELS];

    wsd_stream_line #(.LINE_W(LINE_W)) u_line (
        .clk      (clk),
        .rst      (rst),
        .wb_valid (wb_valid),
        .wb_full  (wb_full),
        .wb_line  (wb_line),
        .ld_valid (ld_valid),
        .ld_line  (ld_line),
        .load_hit (load_hit)
    );

    assign leave = (wb_valid && !wb_full) || load_hit;

    always_comb begin
        ctrl[0].enable  = 1'b1;
        ctrl[0].step    = lf_valid && lf_full;
        ctrl[0].restart = lf_valid && !lf_full;
        ctrl[0].leave   = leave;
        ctrl[1].enable  = l2_present;
        ctrl[1].step    = wb_valid && wb_full;
        ctrl[1].restart = 1'b0;
        ctrl[1].leave   = leave;
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        localparam int TH = (g == 0) ? L1_THRESH : L2_THRESH;
        wsd_mode_ctl #(.THRESH(TH)) u_mode (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctrl[g]),
            .mode (mode[g])
        );
    end

    assign l1_stream_mode = mode[0];
    assign l2_stream_mode = mode[1];
endmodule

// File: rtl/wsd_checks.sv
module wsd_checks (
    input logic clk,
    input logic rst,
    input logic l2_present,
    input logic lf_valid,
    input logic lf_full,
    input logic wb_valid,
    input logic wb_full,
    input logic l1_stream_mode,
    input logic l2_stream_mode
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!l1_stream_mode && !l2_stream_mode));

    assert_l1_entry_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(l1_stream_mode) |-> $past(lf_valid && lf_full));

    assert_partial_exit_R4: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_full) |=> (!l1_stream_mode && !l2_stream_mode));

    assert_l2_entry_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(l2_stream_mode) |-> $past(wb_valid && wb_full && l2_present));

    assert_l2_gated_R7: assert property (@(posedge clk) disable iff (rst)
        !l2_present |=> !l2_stream_mode);
endmodule

bind wsd_top wsd_checks u_chk (
    .clk            (clk),
    .rst            (rst),
    .l2_present     (l2_present),
    .lf_valid       (lf_valid),
    .lf_full        (lf_full),
    .wb_valid       (wb_valid),
    .wb_full        (wb_full),
    .l1_stream_mode (l1_stream_mode),
    .l2_stream_mode (l2_stream_mode)
);

// File: tb/wsd_top_tb.sv
module wsd_top_tb;
    localparam int LW = 26;
    localparam int T1 = 3;
    localparam int T2 = 127;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l2_present = 1'b1;
    logic lf_valid = 0, lf_full = 0, wb_valid = 0, wb_full = 0, ld_valid = 0;
    logic [LW-1:0] wb_line = '0, ld_line = '0;
    logic l1_stream_mode, l2_stream_mode;

    int errors = 0, checks = 0;
    bit done = 0;

    int c1 = 0, c2 = 0;
    bit m1 = 0, m2 = 0, sv = 0;
    logic [LW-1:0] saddr = '0;

    always #5 clk = ~clk;

    wsd_top u_dut (
        .clk(clk), .rst(rst), .l2_present(l2_present),
        .lf_valid(lf_valid), .lf_full(lf_full),
        .wb_valid(wb_valid), .wb_full(wb_full), .wb_line(wb_line),
        .ld_valid(ld_valid), .ld_line(ld_line),
        .l1_stream_mode(l1_stream_mode), .l2_stream_mode(l2_stream_mode)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        bit hit, lv;
        hit = ld_valid && sv && (ld_line == saddr);
        lv  = (wb_valid && !wb_full) || hit;
        if (lv) begin c1 = 0; m1 = 0; end
        else if (lf_valid && !lf_full) c1 = 0;
        else if (lf_valid && lf_full) begin
            if (c1 < T1) c1++;
            if (c1 >= T1) m1 = 1;
        end
        if (!l2_present || lv) begin c2 = 0; m2 = 0; end
        else if (wb_valid && wb_full) begin
            if (c2 < T2) c2++;
            if (c2 >= T2) m2 = 1;
        end
        if (wb_valid) begin
            sv = wb_full;
            if (wb_full) saddr = wb_line;
        end
    endtask

    task automatic step(input bit lfv, lff, wbv, wbf, input logic [LW-1:0] wba,
                        input bit ldv, input logic [LW-1:0] lda, input string tag);
        @(negedge clk);
        lf_valid = lfv; lf_full = lff; wb_valid = wbv; wb_full = wbf;
        wb_line = wba; ld_valid = ldv; ld_line = lda;
        @(posedge clk);
        model_update();
        #1;
        check(tag, l1_stream_mode, m1, "l1_stream_mode");
        check(tag, l2_stream_mode, m2, "l2_stream_mode");
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, '0, 0, '0, tag);
    endtask

    task automatic fill(input bit full, input string tag);
        step(1, full, 0, 0, '0, 0, '0, tag);
    endtask

    task automatic burst(input bit full, input logic [LW-1:0] a, input string tag);
        step(0, 0, 1, full, a, 0, '0, tag);
    endtask

    task automatic load(input logic [LW-1:0] a, input string tag);
        step(0, 0, 0, 0, '0, 1, a, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1", l1_stream_mode, 1'b0, "l1 after reset");
        check("R1", l2_stream_mode, 1'b0, "l2 after reset");
        idle("R1");

        // R10-like: load with no streamed line has no effect (R5)
        load(26'h55, "R5");
        // R2: two full fills not enough, third enters
        fill(1, "R2"); fill(1, "R2");
        check("R2", l1_stream_mode, 1'b0, "below threshold");
        fill(1, "R2");
        check("R2", l1_stream_mode, 1'b1, "at threshold");
        // R8: saturation, stays set
        repeat (5) fill(1, "R8");
        check("R8", l1_stream_mode, 1'b1, "saturated");
        // R3: partial fill keeps mode set
        fill(0, "R3");
        check("R3", l1_stream_mode, 1'b1, "mode kept on partial fill");
        // R4: partial burst exits
        burst(0, 26'h10, "R4");
        check("R4", l1_stream_mode, 1'b0, "exit on partial burst");
        // R3: run reset by partial fill
        fill(1, "R3"); fill(1, "R3"); fill(0, "R3"); fill(1, "R3"); fill(1, "R3");
        check("R3", l1_stream_mode, 1'b0, "run restarted");
        fill(1, "R3");
        check("R3", l1_stream_mode, 1'b1, "re-entry after fresh run");
        // R5: load to other line keeps mode; load to streamed line exits
        burst(1, 26'h200, "R5");
        load(26'h201, "R5");
        check("R5", l1_stream_mode, 1'b1, "other-line load ignored");
        load(26'h200, "R5");
        check("R5", l1_stream_mode, 1'b0, "streamed-line load exits");
        // R9: exit and qualifying fill together
        fill(1, "R9"); fill(1, "R9");
        step(1, 1, 1, 0, 26'h3, 0, '0, "R9");
        check("R9", l1_stream_mode, 1'b0, "exit wins");
        fill(1, "R9"); fill(1, "R9");
        check("R9", l1_stream_mode, 1'b0, "counter cleared by exit");
        fill(1, "R9");

        // R6: L2 threshold
        for (int i = 0; i < T2 - 1; i++) burst(1, 26'h1000 + i, "R6");
        check("R6", l2_stream_mode, 1'b0, "one below L2 threshold");
        burst(1, 26'h2000, "R6");
        check("R6", l2_stream_mode, 1'b1, "at L2 threshold");
        repeat (3) burst(1, 26'h2001, "R8");
        check("R8", l2_stream_mode, 1'b1, "L2 saturated");
        load(26'h2001, "R5");
        check("R5", l2_stream_mode, 1'b0, "L2 exit on streamed-line load");

        // R4 on secondary counter: partial resets run
        for (int i = 0; i < T2 - 1; i++) burst(1, 26'h3000 + i, "R4");
        burst(0, 26'h4, "R4");
        burst(1, 26'h5, "R4");
        check("R4", l2_stream_mode, 1'b0, "L2 run reset by partial");

        // R7: no L2 present
        @(negedge clk); l2_present = 0;
        for (int i = 0; i < T2 + 3; i++) burst(1, 26'h6000 + i, "R7");
        check("R7", l2_stream_mode, 1'b0, "gated without L2");
        @(negedge clk); l2_present = 1;
        burst(1, 26'h7, "R7");
        check("R7", l2_stream_mode, 1'b0, "count did not build while absent");

        idle("R1");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule